// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters as asynchronous NRZ frames on a single output pin. A character is written through a one-cycle write strobe into a one-deep holding register. From there it moves into a frame shifter, which sends a start bit, the data bits least significant first, an optional ninth bit and one or two stop bits. Bit boundaries come from an external baud-tick strobe, so baud-rate generation stays outside the block.

The holding register lets software queue the next character while the current one is still on the wire. The queued character enters the shifter on the same clock edge on which the last stop bit ends, so consecutive frames have no idle gap. A registered buffer-empty flag, gated by an interrupt enable, tells software when it may write again. A polarity control inverts the whole line, idle level included. Dropping any of the three enable controls aborts the frame in progress and discards any pending character.

Top module: `dbt_tx`

## Requirements
- R1: The line idles at mark (logical 1). A frame is a start bit at space (0), then the data, then stop bits at mark. The pin also sits at mark whenever the transmitter is inactive.
- R2: The 8 data bits are sent least significant bit first. Each bit holds from one baud tick to the next. The start bit runs from the load edge to the first tick that follows.
- R3: With `nine_bit_i`=1, the value of `wr_bit8_i` captured with the write is sent as a ninth data bit after bit 7.
- R4: `two_stop_i`=0 gives one stop bit and `two_stop_i`=1 gives two stop bits. The data length and stop count are taken when the character enters the shifter.
- R5: The transmitter is active only when `tx_en_i`=1, `port_en_i`=1 and `sync_sel_i`=0. Writes made while it is inactive are ignored.
- R6: A write made while the shifter is idle loads the shifter on that edge. The start bit is on the pin from the next cycle, and the buffer-empty flag does not drop.
- R7: A write made while a frame is in progress is held until the tick that ends the last stop bit. The held character loads on that edge, and its start bit follows with no idle interval. A second write made while a character is already pending replaces it.
- R8: `buf_empty_o` is 1 exactly when the transmitter has been active for a cycle and no character is pending. It rises one edge after enabling, and there is no way to write it.
- R9: After a write that is held, `buf_empty_o` still reads 1 in the cycle after the write edge. It reads 0 from the second edge onward.
- R10: `irq_o` equals `buf_empty_o` AND `irq_en_i`. The flag updates regardless of `irq_en_i`.
- R11: With `invert_i`=1, the pin carries the complement of every level, idle included.
- R12: Clearing any enable aborts the current frame. On the next edge the pin returns to idle, `busy_o` drops to 0 and `buf_empty_o` drops to 0. The pending character is discarded and is never sent after re-enabling.
- R13: `busy_o` is 1 from the load edge until the last stop bit of the last queued frame ends. It stays 1 across back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| port_en_i | input | 1 | Serial port enable |
| sync_sel_i | input | 1 | Synchronous mode select; must be 0 for the block to transmit |
| nine_bit_i | input | 1 | 1 selects nine data bits |
| two_stop_i | input | 1 | 1 selects two stop bits |
| invert_i | input | 1 | Output polarity invert |
| irq_en_i | input | 1 | Interrupt enable |
| baud_tick_i | input | 1 | One-cycle strobe marking each bit boundary |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character data bits 7..0 |
| wr_bit8_i | input | 1 | Ninth data bit |
| tx_o | output | 1 | Serial output pin |
| buf_empty_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Gated transmit interrupt |
| busy_o | output | 1 | Shifter busy |

## Verification
The bench decodes every frame at the centre of each baud interval and checks it against a queue of expected characters. It also records how many idle intervals come before each start bit. A design that waits one tick too long before loading the held character would leave a gap before the start bit. A design that gets the stop count or the ninth-bit position wrong would see the next start bit land where a stop bit is expected. The bench samples the buffer-empty flag cycle by cycle after a held write, so a flag that is registered one stage too many, or not registered at all, is caught. Two further cases are covered: a frame aborted while a second character is pending, which must not appear after re-enabling, and writes made while the block is inactive, which must leave the pin idle.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int unsigned DW = 8;          // base data bits
  localparam int unsigned FW = DW + 4;     // start + data + ninth + two stop
  localparam int unsigned CW = $clog2(FW);

  typedef struct packed {
    logic          ext;
    logic [DW-1:0] low;
  } char_t;
endpackage

// File: rtl/dbt_hold.sv
module dbt_hold
  import dbt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  input  logic  wr_i,
  input  char_t wr_char_i,
  input  logic  shift_free_i,
  output logic  load_o,
  output char_t load_char_o,
  output logic  empty_o
);
  logic  valid_q;
  char_t data_q;
  logic  empty_q;

  // direct load when nothing is pending, else drain the holding register
  assign load_o      = active_i & shift_free_i & (valid_q | wr_i);
  assign load_char_o = valid_q ? data_q : wr_char_i;
  assign empty_o     = empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      empty_q <= 1'b0;
    end else begin
      empty_q <= active_i & ~valid_q;
      if (!active_i) begin
        valid_q <= 1'b0;
      end else if (wr_i && (valid_q || !shift_free_i)) begin
        valid_q <= 1'b1;
        data_q  <= wr_char_i;
      end else if (valid_q && shift_free_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R9
  wr_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && wr_i && !shift_free_i) ##1 active_i |=> !empty_q);

  // R12
  hold_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!valid_q && !empty_q));
endmodule

// File: rtl/dbt_shift.sv
module dbt_shift
  import dbt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  active_i,
  input  logic  tick_i,
  input  logic  load_i,
  input  char_t load_char_i,
  input  logic  nine_i,
  input  logic  two_i,
  output logic  free_o,
  output logic  busy_o,
  output logic  line_o
);
  logic          busy_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;
  logic          last_bit;

  assign last_bit = busy_q & tick_i & (cnt_q == last_q);
  assign free_o   = ~busy_q | last_bit;
  assign busy_o   = busy_q;
  assign line_o   = ~busy_q | sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (!active_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sh_q   <= {2'b11, (nine_i ? load_char_i.ext : 1'b1), load_char_i.low, 1'b0};
      cnt_q  <= '0;
      last_q <= CW'(DW + 1) + CW'(nine_i) + CW'(two_i);
    end else if (last_bit) begin
      busy_q <= 1'b0;
    end else if (busy_q && tick_i) begin
      sh_q  <= {1'b1, sh_q[FW-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_q && !line_o));

  // R2
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && busy_q && !tick_i && !load_i) |=> $stable(line_o));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= last_q));

  // R12
  shift_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!busy_q && line_o));
endmodule

// File: rtl/dbt_tx.sv
module dbt_tx
  import dbt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic          port_en_i,
  input  logic          sync_sel_i,
  input  logic          nine_bit_i,
  input  logic          two_stop_i,
  input  logic          invert_i,
  input  logic          irq_en_i,
  input  logic          baud_tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_bit8_i,
  output logic          tx_o,
  output logic          buf_empty_o,
  output logic          irq_o,
  output logic          busy_o
);
  logic  active;
  logic  shift_free, load, empty, line;
  char_t wr_char, load_char;

  assign active  = tx_en_i & port_en_i & ~sync_sel_i;
  assign wr_char = '{ext: wr_bit8_i, low: wr_data_i};

  dbt_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .wr_i        (wr_i),
    .wr_char_i   (wr_char),
    .shift_free_i(shift_free),
    .load_o      (load),
    .load_char_o (load_char),
    .empty_o     (empty)
  );

  dbt_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .tick_i     (baud_tick_i),
    .load_i     (load),
    .load_char_i(load_char),
    .nine_i     (nine_bit_i),
    .two_i      (two_stop_i),
    .free_o     (shift_free),
    .busy_o     (busy_o),
    .line_o     (line)
  );

  assign tx_o        = line ^ invert_i;
  assign buf_empty_o = empty;
  assign irq_o       = empty & irq_en_i;

  // R11
  idle_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tx_o == ~invert_i));
endmodule

// File: tb/sim_dbt_tx.sv
module sim_dbt_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, port_en, sync_sel, nine, two, inv, irq_en, tick, wr, b8;
  logic [7:0] wdata;
  logic       tx_o, buf_empty_o, irq_o, busy_o;

  always #10 clk = ~clk;

  dbt_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .port_en_i(port_en),
    .sync_sel_i(sync_sel), .nine_bit_i(nine), .two_stop_i(two), .invert_i(inv),
    .irq_en_i(irq_en), .baud_tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .wr_bit8_i(b8), .tx_o(tx_o), .buf_empty_o(buf_empty_o), .irq_o(irq_o),
    .busy_o(busy_o)
  );

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int frames = 0;
  int pushed = 0;
  int idle_run = 0;
  int last_gap = 0;
  int pos = 0;
  bit done = 0;
  bit mon_on = 0;
  bit in_f = 0;
  bit cfg_nine = 0, cfg_two = 0, cfg_inv = 0;
  logic [8:0] acc;
  logic [8:0] expq[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;
  // tick sampled on the edge where cyc becomes a multiple of 8
  always @(negedge clk) tick = (cyc % 8 == 7);

  // monitor: sample at interval centres
  always @(negedge clk) begin
    logic ln;
    int   ndata;
    if (mon_on && (cyc % 8 == 4)) begin
      ln = tx_o ^ cfg_inv;
      ndata = cfg_nine ? 9 : 8;
      if (!in_f) begin
        if (!ln) begin
          in_f = 1; pos = 0; acc = '0; last_gap = idle_run; idle_run = 0;
        end else idle_run++;
      end else begin
        if (pos < ndata) acc[pos] = ln;
        else chk(ln == 1'b1, "R4 stop bit level", 32'(ln), 32'd1);
        pos++;
        if (pos == ndata + (cfg_two ? 2 : 1)) begin
          in_f = 0;
          frames++;
          if (expq.size() == 0) chk(0, "R2 unexpected frame", 32'(acc), 32'h0);
          else begin
            logic [8:0] e;
            e = expq.pop_front();
            chk(acc == e, "R2/R3 frame content", 32'(acc), 32'(e));
          end
        end
      end
    end
  end

  task automatic phase(input int p);
    do @(negedge clk); while (cyc % 8 != p);
  endtask

  task automatic send(input logic [7:0] d, input logic x, input bit push);
    phase(0);
    wdata = d; b8 = x; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (push) begin
      expq.push_back({cfg_nine ? x : 1'b0, d});
      pushed++;
    end
  endtask

  task automatic drain;
    while (expq.size() != 0 || busy_o) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    bit saw_low;
    rst_n = 0; tx_en = 0; port_en = 0; sync_sel = 0; nine = 0; two = 0;
    inv = 0; irq_en = 0; wr = 0; wdata = '0; b8 = 0; tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_o == 1'b1, "R1 reset idle", 32'(tx_o), 1);
    chk(buf_empty_o == 1'b0, "R8 flag low while inactive", 32'(buf_empty_o), 0);
    chk(busy_o == 1'b0, "R13 reset busy", 32'(busy_o), 0);
    chk(irq_o == 1'b0, "R10 reset irq", 32'(irq_o), 0);

    // R5: writes while inactive
    port_en = 1;
    send(8'h55, 0, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && tx_o == 1'b1, "R5 write ignored with tx disabled", 32'({busy_o, tx_o}), 1);
    tx_en = 1; sync_sel = 1;
    send(8'h66, 0, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && tx_o == 1'b1, "R5 write ignored in sync mode", 32'({busy_o, tx_o}), 1);
    chk(buf_empty_o == 1'b0, "R5 flag low in sync mode", 32'(buf_empty_o), 0);

    // R8 enable
    sync_sel = 0;
    @(negedge clk);
    chk(buf_empty_o == 1'b1, "R8 flag high after enable", 32'(buf_empty_o), 1);
    chk(irq_o == 1'b0, "R10 irq masked", 32'(irq_o), 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq_o == 1'b1, "R10 irq follows flag", 32'(irq_o), 1);

    // R6 direct load
    mon_on = 1;
    send(8'hA5, 0, 1);
    chk(busy_o == 1'b1 && tx_o == 1'b0, "R6 start bit at once", 32'({busy_o, tx_o}), 32'h2);
    chk(buf_empty_o == 1'b1, "R6 flag stays high on direct load", 32'(buf_empty_o), 1);
    drain();
    chk(frames == 1, "R2 single frame seen", frames, 1);

    // R9 flag latency and R7 back-to-back
    send(8'h3C, 0, 1);
    phase(0);
    wdata = 8'hC5; b8 = 0; wr = 1;
    @(negedge clk);
    wr = 0;
    chk(buf_empty_o == 1'b1, "R9 flag unchanged one cycle after write", 32'(buf_empty_o), 1);
    @(negedge clk);
    chk(buf_empty_o == 1'b0, "R9 flag low from second edge", 32'(buf_empty_o), 0);
    chk(irq_o == 1'b0, "R10 irq low with flag", 32'(irq_o), 0);
    expq.push_back(9'h0C5); pushed++;
    while (!buf_empty_o) @(negedge clk);
    send(8'h12, 0, 0);
    phase(0);
    wdata = 8'h96; wr = 1;            // R7 replaces the pending 0x12
    @(negedge clk);
    wr = 0;
    expq.push_back(9'h096); pushed++;
    saw_low = 0;
    while (expq.size() != 0) begin
      @(negedge clk);
      if (!busy_o) saw_low = 1;
    end
    chk(!saw_low, "R13 busy held across back-to-back frames", 32'(saw_low), 0);
    chk(last_gap == 0, "R7 no idle interval between frames", last_gap, 0);
    drain();
    chk(busy_o == 1'b0, "R13 busy clears after last stop", 32'(busy_o), 0);

    // R3 and R4: nine bits, two stops, back-to-back
    nine = 1; two = 1; cfg_nine = 1; cfg_two = 1;
    send(8'h81, 1, 1);
    send(8'h7E, 0, 1);
    while (expq.size() != 0) @(negedge clk);
    chk(last_gap == 0, "R4 two stop bits then immediate start", last_gap, 0);
    drain();

    // R11 polarity
    nine = 0; two = 0; cfg_nine = 0; cfg_two = 0;
    inv = 1; cfg_inv = 1;
    @(negedge clk);
    chk(tx_o == 1'b0, "R11 inverted idle", 32'(tx_o), 0);
    send(8'hC3, 0, 1);
    chk(tx_o == 1'b1, "R11 inverted start bit", 32'(tx_o), 1);
    drain();
    inv = 0; cfg_inv = 0;

    // R12 abort with a pending character
    mon_on = 0;
    send(8'hF0, 0, 0);
    send(8'h0F, 0, 0);
    phase(2);
    tx_en = 0;
    @(negedge clk);
    chk(tx_o == 1'b1 && busy_o == 1'b0, "R12 abort idles pin", 32'({busy_o, tx_o}), 1);
    chk(buf_empty_o == 1'b0, "R12 flag low while disabled", 32'(buf_empty_o), 0);
    tx_en = 1;
    saw_low = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy_o || !tx_o) saw_low = 1;
    end
    chk(!saw_low, "R12 pending character discarded", 32'(saw_low), 0);
    chk(buf_empty_o == 1'b1, "R8 flag back after re-enable", 32'(buf_empty_o), 1);

    in_f = 0; idle_run = 0; mon_on = 1;
    send(8'h5A, 0, 1);
    drain();
    chk(frames == pushed, "R2 frame count", frames, pushed);
    chk(expq.size() == 0, "R2 queue drained", expq.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule